// File: doc/BRIEF.md
# Shifted-Modulus Remainder Unit

This block computes the remainder of a 2W-bit dividend divided by a W-bit modulus. It runs one subtraction per clock. In each cycle it builds every left-shifted copy of the stored modulus, from a shift of 0 up to a shift of W, each zero-extended to 2W bits. It compares all of these copies against the running remainder at the same time and subtracts the widest copy that still fits. The loop ends when even the unshifted modulus no longer fits. A zero modulus is not divided. Instead it produces a zero result and a flag.

The unit takes one operation at a time through a valid/ready input stream and returns each result through a valid/ready output stream. An operand pair is taken on any rising edge where `s_valid` and `s_ready` are both high. `s_ready` is high only while the unit is idle, so a source may hold `s_valid` and its data for as long as it needs to. Once `m_valid` rises, `remainder` and `div_zero` stay fixed until the sink takes them with `m_ready`. A stalled sink therefore holds the whole unit, and no new operand is taken until the result has been consumed. The usual operands are products of two residues. For those the dividend is below modulus·2^W, and the latency is bounded by W+2 edges. Larger dividends still give the correct result but take extra cycles.

Top module: `mod_reducer`

## Requirements
- R1: After reset, and at any time the unit is idle, `s_ready` is 1 and `m_valid` is 0. `s_ready` and `m_valid` are never high together.
- R2: Operands are captured only on a rising edge with `s_valid` and `s_ready` both high. While an operation is in progress, `s_ready` is 0, and any changes on `dividend`, `modulus` or `s_valid` do not alter that operation's result.
- R3: For a nonzero modulus, when `m_valid` is high, `remainder` equals the captured dividend modulo the captured modulus, and `div_zero` is 0.
- R4: A captured modulus of 0 sets `m_valid` high straight after the capture edge, with `remainder` 0 and `div_zero` 1.
- R5: If the dividend is below a nonzero modulus, `m_valid` rises on the second rising edge counted from the capture edge, and `remainder` equals the dividend.
- R6: If the dividend is below modulus·2^W, `m_valid` rises no later than the (W+2)-th rising edge counted from the capture edge.
- R7: While `m_valid` is 1 and `m_ready` is 0, `m_valid`, `remainder` and `div_zero` hold their values.
- R8: The rising edge with `m_valid` and `m_ready` both high ends the operation. After that edge `m_valid` is 0 and `s_ready` is 1.
- R9: Whenever `m_valid` is 1 with `div_zero` 0, `remainder` is strictly less than the captured modulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Operand pair offered |
| s_ready | output | 1 | Unit idle and able to take operands |
| dividend | input | 2W | Value to reduce |
| modulus | input | W | Divisor |
| m_valid | output | 1 | Result available |
| m_ready | input | 1 | Sink takes the result |
| remainder | output | W | dividend mod modulus (0 for a zero modulus) |
| div_zero | output | 1 | Captured modulus was zero |

## Verification
The bound checker watches several properties on every cycle. It checks that `s_ready` and `m_valid` are never high together, that no second operand is taken mid-operation, and that the result holds under back-pressure. It checks that the handshake closes after consumption, that a delivered remainder is below the captured modulus, that a zero-modulus result reads 0, and that in-range operands meet the latency bound. Only the bench scenarios can show that the remainder is numerically correct, since that needs an independent reference. The same goes for the exact two-edge latency when the dividend is already reduced, and for input activity during a run being ignored. The slow path is also bench-only: here a dividend far above the top shifted copy must be walked down by repeated subtractions of that copy.

// File: rtl/mod_reducer_pkg.sv
package mod_reducer_pkg;
  typedef enum logic [1:0] {
    MR_IDLE = 2'd0,
    MR_RUN  = 2'd1,
    MR_DONE = 2'd2
  } mr_state_e;
endpackage

// File: rtl/mr_shift_bank.sv
// Builds every left-shifted copy of the modulus, shift 0..W, at 2W bits.
module mr_shift_bank #(
  parameter int W = 16
) (
  input  logic [W-1:0]          n_val,
  output logic [W:0][2*W-1:0]   cand
);
  localparam int DW = 2 * W;

  for (genvar k = 0; k <= W; k++) begin : g_shift
    assign cand[k] = DW'(n_val) << k;
  end
endmodule

// File: rtl/mr_fit_select.sv
// Compares all candidates with the remainder in parallel and picks the
// highest-index copy that does not exceed it.
module mr_fit_select #(
  parameter int W = 16
) (
  input  logic [2*W-1:0]        rem,
  input  logic [W:0][2*W-1:0]   cand,
  output logic [2*W-1:0]        pick,
  output logic                  base_fits
);
  localparam int NC = W + 1;

  logic [NC-1:0] fit;

  for (genvar k = 0; k < NC; k++) begin : g_cmp
    assign fit[k] = (cand[k] <= rem);
  end

  always_comb begin
    pick = '0;
    for (int k = 0; k < NC; k++) begin
      if (fit[k]) pick = cand[k];
    end
  end

  assign base_fits = fit[0];
endmodule

// File: rtl/mod_reducer.sv
module mod_reducer
  import mod_reducer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [2*W-1:0]    dividend,
  input  logic [W-1:0]      modulus,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [W-1:0]      remainder,
  output logic              div_zero
);
  localparam int DW = 2 * W;

  mr_state_e             state_q;
  logic [DW-1:0]         rem_q;
  logic [W-1:0]          n_q;
  logic                  dz_q;
  logic [W:0][DW-1:0]    cand;
  logic [DW-1:0]         pick;
  logic                  base_fits;

  mr_shift_bank #(.W(W)) u_bank (
    .n_val (n_q),
    .cand  (cand)
  );

  mr_fit_select #(.W(W)) u_sel (
    .rem       (rem_q),
    .cand      (cand),
    .pick      (pick),
    .base_fits (base_fits)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= MR_IDLE;
      rem_q   <= '0;
      n_q     <= '0;
      dz_q    <= 1'b0;
    end else begin
      unique case (state_q)
        MR_IDLE: begin
          if (s_valid) begin
            n_q  <= modulus;
            dz_q <= (modulus == '0);
            if (modulus == '0) begin
              rem_q   <= '0;
              state_q <= MR_DONE;
            end else begin
              rem_q   <= dividend;
              state_q <= MR_RUN;
            end
          end
        end
        MR_RUN: begin
          if (base_fits) rem_q   <= rem_q - pick;
          else           state_q <= MR_DONE;
        end
        MR_DONE: begin
          if (m_ready) state_q <= MR_IDLE;
        end
        default: state_q <= MR_IDLE;
      endcase
    end
  end

  assign s_ready   = (state_q == MR_IDLE);
  assign m_valid   = (state_q == MR_DONE);
  assign remainder = rem_q[W-1:0];
  assign div_zero  = dz_q;
endmodule

// File: rtl/mod_reducer_chk.sv
module mod_reducer_chk #(
  parameter int W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic              s_ready,
  input logic [2*W-1:0]    dividend,
  input logic [W-1:0]      modulus,
  input logic              m_valid,
  input logic              m_ready,
  input logic [W-1:0]      remainder,
  input logic              div_zero,
  input logic [W-1:0]      n_q
);
  localparam int DW = 2 * W;
  localparam int LW = $clog2(W + 4) + 2;

  logic [LW-1:0] lat;
  logic          in_range;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat      <= '0;
      in_range <= 1'b0;
    end else if (s_valid && s_ready) begin
      lat      <= LW'(1);
      in_range <= (dividend < {modulus, {W{1'b0}}});
    end else if (!s_ready && !m_valid && lat != {LW{1'b1}}) begin
      lat <= lat + 1'b1;
    end
  end

  // R1
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_ready && m_valid));

  // R2
  no_recapture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  // R7
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(remainder) && $stable(div_zero)));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready) |=> (!m_valid && s_ready));

  // R9
  below_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !div_zero) |-> (remainder < n_q));

  // R4
  zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && div_zero) |-> (remainder == '0));

  // R6
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && in_range) |-> (int'(lat) <= W + 2));
endmodule

bind mod_reducer mod_reducer_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_valid   (s_valid),
  .s_ready   (s_ready),
  .dividend  (dividend),
  .modulus   (modulus),
  .m_valid   (m_valid),
  .m_ready   (m_ready),
  .remainder (remainder),
  .div_zero  (div_zero),
  .n_q       (n_q)
);

// File: tb/mod_reducer_tb.sv
`timescale 1ns/1ps
module mod_reducer_tb;
  localparam int W  = 16;
  localparam int DW = 2 * W;
  localparam int TMO = 70000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [DW-1:0] dividend = '0;
  logic [W-1:0]  modulus = '0;
  logic          m_valid;
  logic          m_ready = 1'b0;
  logic [W-1:0]  remainder;
  logic          div_zero;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mod_reducer #(.W(W)) u_dut (
    .clk (clk), .rst_n (rst_n), .s_valid (s_valid), .s_ready (s_ready),
    .dividend (dividend), .modulus (modulus), .m_valid (m_valid),
    .m_ready (m_ready), .remainder (remainder), .div_zero (div_zero)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_mod(input logic [DW-1:0] a, input logic [W-1:0] b);
    if (b == '0) return '0;
    return W'(a % DW'(b));
  endfunction

  // Offers one operand pair, waits for the result, leaves it unconsumed.
  task automatic issue(input logic [DW-1:0] dv, input logic [W-1:0] mv,
                       output logic [W-1:0] res, output logic dz, output int lat);
    @(negedge clk);
    chk(s_ready == 1'b1, "R1", s_ready, 1);
    s_valid = 1'b1; dividend = dv; modulus = mv; m_ready = 1'b0;
    @(negedge clk);
    s_valid = 1'b0;
    lat = 1;
    while (!m_valid && lat < TMO) begin
      @(negedge clk);
      lat++;
    end
    res = remainder;
    dz  = div_zero;
  endtask

  task automatic consume();
    m_ready = 1'b1;
    @(negedge clk);
    m_ready = 1'b0;
    // R8
    chk(m_valid == 1'b0 && s_ready == 1'b1, "R8", {m_valid, s_ready}, 1);
  endtask

  task automatic run_op(input logic [DW-1:0] dv, input logic [W-1:0] mv, input string req);
    logic [W-1:0] res; logic dz; int lat;
    issue(dv, mv, res, dz, lat);
    chk(m_valid == 1'b1, "R3 timeout", m_valid, 1);
    chk(res == ref_mod(dv, mv) && dz == (mv == '0), req, {dz, res}, {(mv == '0), ref_mod(dv, mv)});
    if (mv != '0 && dv < {mv, {W{1'b0}}})
      chk(lat <= W + 2, "R6", lat, W + 2);
    consume();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(s_ready == 1'b1 && m_valid == 1'b0, "R1", {s_ready, m_valid}, 2);
  endtask

  task automatic t_basic();
    run_op(32'd1000, 16'd7, "R3");
    run_op(32'h1234_5678, 16'hABCD, "R3");
    run_op(32'h00FF_FFFF, 16'h0100, "R3");
    run_op(32'hFFFE_0001, 16'hFFFF, "R3");
  endtask

  task automatic t_small();
    logic [W-1:0] res; logic dz; int lat;
    issue(32'd5, 16'd9, res, dz, lat);
    // R5
    chk(lat == 2, "R5", lat, 2);
    chk(res == 16'd5, "R5", res, 5);
    consume();
    run_op(32'd9, 16'd9, "R3");
    run_op(32'd0, 16'd1, "R3");
  endtask

  task automatic t_extremes();
    run_op({DW{1'b1}}, 16'd1, "R3");
    run_op({DW{1'b1}}, 16'hFFFF, "R3");
    run_op({DW{1'b1}}, 16'h8000, "R3");
  endtask

  task automatic t_zero();
    logic [W-1:0] res; logic dz; int lat;
    issue(32'd1234, 16'd0, res, dz, lat);
    // R4
    chk(lat == 1, "R4", lat, 1);
    chk(res == '0 && dz == 1'b1, "R4", {dz, res}, {1'b1, 16'h0});
    consume();
    run_op(32'd1234, 16'd10, "R3");
  endtask

  task automatic t_backpressure();
    logic [W-1:0] res; logic dz; int lat;
    issue(32'h0003_4567, 16'h0123, res, dz, lat);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      // R7
      chk(m_valid == 1'b1 && remainder == res && div_zero == dz, "R7", remainder, res);
    end
    chk(res == ref_mod(32'h0003_4567, 16'h0123), "R3", res, ref_mod(32'h0003_4567, 16'h0123));
    consume();
  endtask

  task automatic t_ignore();
    int lat;
    @(negedge clk);
    s_valid = 1'b1; dividend = 32'h0009_ABCD; modulus = 16'h0321;
    @(negedge clk);
    dividend = 32'h0000_0011; modulus = 16'h0005;
    lat = 1;
    // R2
    chk(s_ready == 1'b0, "R2", s_ready, 0);
    while (!m_valid && lat < TMO) begin
      @(negedge clk);
      dividend = dividend + 1;
      lat++;
    end
    s_valid = 1'b0;
    chk(remainder == ref_mod(32'h0009_ABCD, 16'h0321), "R2", remainder, ref_mod(32'h0009_ABCD, 16'h0321));
    consume();
  endtask

  task automatic t_random();
    for (int i = 0; i < 150; i++) begin
      logic [W-1:0] mv, a, b;
      logic [DW-1:0] dv;
      mv = W'($urandom);
      if (mv == '0) mv = 16'd3;
      if (i % 2 == 0) begin
        a  = W'($urandom) % mv;
        b  = W'($urandom) % mv;
        dv = DW'(a) * DW'(b);
      end else begin
        mv[W-1] = 1'b1;
        dv = DW'($urandom);
      end
      run_op(dv, mv, "R3");
    end
  endtask

  initial begin
    t_reset();
    t_basic();
    t_small();
    t_extremes();
    t_zero();
    t_backpressure();
    t_ignore();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule